// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit-Timing Front End

This block is the physical-layer slave for one open-drain single-wire bus line. It samples the line through a synchronizer and drives a single pull-low enable. Every event on the line is timed in clock ticks from the falling edge the master makes. A long low is a bus reset, and the block answers it with a presence pulse. A short or long low in a write slot becomes a received bit. In a read slot the block holds the line low when it has a zero to send.

Two speeds are supported: standard and overdrive. The layer above raises overdrive with a one-cycle request. Any reset whose low lasts the full standard reset length drops the block back to standard speed. A shorter reset taken at overdrive speed keeps overdrive; this includes the lengths for which the speed is left undefined. After each rising edge a hold-off window runs, and a low that begins and ends inside it is dropped as a glitch.

The controller has six states. IDLE waits for a falling edge (IDLE to LOW). LOW times the master's low: a release below the reset length goes to HOLDOFF, and a release at or above it goes to PD_WAIT. HOLDOFF runs the glitch window and then goes to IDLE if the line is high or to LOW if it is still low. PD_WAIT is the quiet gap before presence, which goes to PD_LOW. PD_LOW drives the presence pulse and then goes to PD_REL. PD_REL waits for the line to rise and then goes to HOLDOFF.

Top module: `ow_slave_phy`

## Requirements
- R1: After reset the block does not pull the line, reports standard speed (od_active = 0), and gives no strobe.
- R2: At standard speed, a low of 480 us or more gives exactly one bus_reset strobe at the release. It is followed by a presence low that covers 65 to 75 us after the release.
- R3: At standard speed, a low shorter than 480 us gives no bus_reset and no presence pulse.
- R4: At overdrive speed, a low of 48 us up to below 480 us gives one bus_reset and keeps od_active = 1. The presence low then covers 7 to 10 us after the release.
- R5: A low of 480 us or more at any speed gives bus_reset, sets od_active to 0, and uses standard presence timing.
- R6: A one-cycle od_set pulse makes od_active 1 from the next cycle, unless a reset of 480 us or more ends in the same cycle.
- R7: In a write slot (tx_req = 0 at the falling edge), a release before the sample point (30 us standard, 3 us overdrive) gives one rx_valid with rx_bit = 1. A line still low at the sample point gives one rx_valid with rx_bit = 0.
- R8: In a read slot (tx_req = 1 at the falling edge), tx_bit = 0 keeps the line low through the end of the master window (15 us standard, 2 us overdrive). tx_bit = 1 never pulls the line. The slot gives one tx_done and no rx_valid.
- R9: A low that starts and ends inside the hold-off window after a rising edge has no effect. A low that lasts past the window starts a new slot.
- R10: The block pulls the line only for a presence pulse or a read-zero slot.
- R11: At overdrive speed, a low shorter than 48 us (for example 30 us) is not a reset. It is received as a write-zero and od_active stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw level of the bus line (asynchronous) |
| od_set | input | 1 | One-cycle request from the upper layer to enter overdrive |
| tx_req | input | 1 | Marks the next slot as a read slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| line_pull | output | 1 | Enable for the open-drain pull-low driver |
| bus_reset | output | 1 | One-cycle strobe on a detected bus reset |
| rx_valid | output | 1 | One-cycle strobe for a received write-slot bit |
| rx_bit | output | 1 | Value of the received bit, valid with rx_valid |
| tx_done | output | 1 | One-cycle strobe when a read slot has finished |
| od_active | output | 1 | Current speed: 1 is overdrive, 0 is standard |

## Verification
Most faults in this block appear on the line itself. A wrong state or a wrong speed selection moves or drops the presence pulse, or leaves the line pulled when only the master should drive it. The bench sees this at the master's sample point, within one slot or one reset sequence. A speed register fault shows on od_active within a cycle or two of the reset release or the od_set pulse, because the bench compares it against its own speed model on every clock. A slot-type or glitch-window fault shows as a missing, extra or inverted rx_valid or tx_done before the next slot starts.

// File: rtl/ow_slave_pkg.sv
package ow_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HOLDOFF,
        ST_PD_WAIT,
        ST_PD_LOW,
        ST_PD_REL
    } ow_state_e;

    // Convert a duration given in quarter microseconds to clock ticks (rounded up, never zero).
    function automatic int unsigned qus_to_cyc(input int unsigned tpu, input int unsigned qus);
        int unsigned c;
        c = (tpu * qus + 3) / 4;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_in};
        end
    end

    assign line_s = sync_q[STAGES-1];
endmodule

// File: rtl/ow_tick_counter.sv
module ow_tick_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!(&cnt)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ow_speed_ctl.sv
module ow_speed_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic od_set,
    input  logic rst_evt,
    input  logic long_rst,
    output logic od
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            od <= 1'b0;
        end else if (rst_evt && long_rst) begin
            od <= 1'b0;
        end else if (od_set) begin
            od <= 1'b1;
        end
    end
endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy
    import ow_slave_pkg::*;
#(
    parameter int unsigned TICKS_PER_US     = 125,
    parameter int unsigned SYNC_STAGES      = 2,
    parameter int unsigned RST_STD_US       = 480,
    parameter int unsigned RST_OD_US        = 48,
    parameter int unsigned PD_WAIT_STD_US   = 20,
    parameter int unsigned PD_LOW_STD_US    = 100,
    parameter int unsigned PD_WAIT_OD_US    = 2,
    parameter int unsigned PD_LOW_OD_US     = 12,
    parameter int unsigned SAMP_STD_US      = 30,
    parameter int unsigned SAMP_OD_US       = 3,
    parameter int unsigned RDHOLD_STD_US    = 30,
    parameter int unsigned RDHOLD_OD_US     = 3,
    parameter int unsigned HOLD_STD_QUS     = 4,
    parameter int unsigned HOLD_OD_QUS      = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic od_set,
    input  logic tx_req,
    input  logic tx_bit,
    output logic line_pull,
    output logic bus_reset,
    output logic rx_valid,
    output logic rx_bit,
    output logic tx_done,
    output logic od_active
);
    localparam int unsigned C_RST_STD  = qus_to_cyc(TICKS_PER_US, 4 * RST_STD_US);
    localparam int unsigned C_RST_OD   = qus_to_cyc(TICKS_PER_US, 4 * RST_OD_US);
    localparam int unsigned C_PDW_STD  = qus_to_cyc(TICKS_PER_US, 4 * PD_WAIT_STD_US);
    localparam int unsigned C_PDL_STD  = qus_to_cyc(TICKS_PER_US, 4 * PD_LOW_STD_US);
    localparam int unsigned C_PDW_OD   = qus_to_cyc(TICKS_PER_US, 4 * PD_WAIT_OD_US);
    localparam int unsigned C_PDL_OD   = qus_to_cyc(TICKS_PER_US, 4 * PD_LOW_OD_US);
    localparam int unsigned C_SMP_STD  = qus_to_cyc(TICKS_PER_US, 4 * SAMP_STD_US);
    localparam int unsigned C_SMP_OD   = qus_to_cyc(TICKS_PER_US, 4 * SAMP_OD_US);
    localparam int unsigned C_RDH_STD  = qus_to_cyc(TICKS_PER_US, 4 * RDHOLD_STD_US);
    localparam int unsigned C_RDH_OD   = qus_to_cyc(TICKS_PER_US, 4 * RDHOLD_OD_US);
    localparam int unsigned C_HLD_STD  = qus_to_cyc(TICKS_PER_US, HOLD_STD_QUS);
    localparam int unsigned C_HLD_OD   = qus_to_cyc(TICKS_PER_US, HOLD_OD_QUS);
    localparam int unsigned CNT_W      = $clog2(C_RST_STD + 2);

    localparam logic [CNT_W-1:0] K_RST_STD = CNT_W'(C_RST_STD);
    localparam logic [CNT_W-1:0] K_RST_OD  = CNT_W'(C_RST_OD);
    localparam logic [CNT_W-1:0] K_SMP_STD = CNT_W'(C_SMP_STD);
    localparam logic [CNT_W-1:0] K_SMP_OD  = CNT_W'(C_SMP_OD);
    localparam logic [CNT_W-1:0] K_RDH_STD = CNT_W'(C_RDH_STD);
    localparam logic [CNT_W-1:0] K_RDH_OD  = CNT_W'(C_RDH_OD);
    localparam logic [CNT_W-1:0] L_PDW_STD = CNT_W'(C_PDW_STD - 1);
    localparam logic [CNT_W-1:0] L_PDL_STD = CNT_W'(C_PDL_STD - 1);
    localparam logic [CNT_W-1:0] L_PDW_OD  = CNT_W'(C_PDW_OD - 1);
    localparam logic [CNT_W-1:0] L_PDL_OD  = CNT_W'(C_PDL_OD - 1);
    localparam logic [CNT_W-1:0] L_HLD_STD = CNT_W'(C_HLD_STD - 1);
    localparam logic [CNT_W-1:0] L_HLD_OD  = CNT_W'(C_HLD_OD - 1);

    ow_state_e        state_q, state_d;
    logic             line_s;
    logic [CNT_W-1:0] cnt;
    logic             od;
    logic             rd_slot_q, rd_val_q;
    logic             is_rst, long_rst;
    logic [CNT_W-1:0] k_rst, k_smp, k_rdh, l_pdw, l_pdl, l_hld;

    ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s)
    );

    ow_tick_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_d != state_q),
        .cnt  (cnt)
    );

    ow_speed_ctl u_speed (
        .clk     (clk),
        .rst_n   (rst_n),
        .od_set  (od_set),
        .rst_evt (bus_reset),
        .long_rst(long_rst),
        .od      (od)
    );

    // Speed-dependent limits.
    always_comb begin
        if (od) begin
            k_rst = K_RST_OD;
            k_smp = K_SMP_OD;
            k_rdh = K_RDH_OD;
            l_pdw = L_PDW_OD;
            l_pdl = L_PDL_OD;
            l_hld = L_HLD_OD;
        end else begin
            k_rst = K_RST_STD;
            k_smp = K_SMP_STD;
            k_rdh = K_RDH_STD;
            l_pdw = L_PDW_STD;
            l_pdl = L_PDL_STD;
            l_hld = L_HLD_STD;
        end
    end

    assign is_rst   = (cnt >= k_rst);
    assign long_rst = (cnt >= K_RST_STD);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!line_s) state_d = ST_LOW;
            ST_LOW:     if (line_s) state_d = is_rst ? ST_PD_WAIT : ST_HOLDOFF;
            ST_HOLDOFF: if (cnt >= l_hld) state_d = line_s ? ST_IDLE : ST_LOW;
            ST_PD_WAIT: if (cnt >= l_pdw) state_d = ST_PD_LOW;
            ST_PD_LOW:  if (cnt >= l_pdl) state_d = ST_PD_REL;
            ST_PD_REL:  if (line_s) state_d = ST_HOLDOFF;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and slot-type capture at each slot start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_slot_q <= 1'b0;
            rd_val_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_d == ST_LOW && state_q != ST_LOW) begin
                rd_slot_q <= tx_req;
                rd_val_q  <= tx_bit;
            end
        end
    end

    // Outputs.
    always_comb begin
        line_pull = (state_q == ST_PD_LOW) ||
                    (state_q == ST_LOW && rd_slot_q && !rd_val_q && cnt < k_rdh);
        bus_reset = (state_q == ST_LOW) && line_s && is_rst;
        rx_valid  = (state_q == ST_LOW) && !rd_slot_q &&
                    ((line_s && cnt < k_smp) || (!line_s && cnt == k_smp));
        rx_bit    = line_s;
        tx_done   = (state_q == ST_LOW) && rd_slot_q && line_s && !is_rst;
        od_active = od;
    end

endmodule

// File: rtl/ow_slave_phy_chk.sv
module ow_slave_phy_chk (
    input logic clk,
    input logic rst_n,
    input logic od_set,
    input logic line_pull,
    input logic bus_reset,
    input logic rx_valid,
    input logic tx_done,
    input logic od_active
);
    // R2: presence is preceded by a released gap, never driven at the reset strobe's next cycle
    a_r2_release_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !line_pull);

    // R2: the reset strobe lasts one cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_reset);

    // R5: leaving overdrive only follows a reset strobe
    a_r5_od_clear_by_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_active) |-> $past(bus_reset));

    // R6: an overdrive request takes effect next cycle
    a_r6_od_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (od_set && !bus_reset) |=> od_active);

    // R7: a received bit never coincides with reset or read completion
    a_r7_rx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!bus_reset && !tx_done));

    // R10: the block never drives during a write slot report
    a_r10_no_pull_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !line_pull);
endmodule

bind ow_slave_phy ow_slave_phy_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .od_set   (od_set),
    .line_pull(line_pull),
    .bus_reset(bus_reset),
    .rx_valid (rx_valid),
    .tx_done  (tx_done),
    .od_active(od_active)
);

// File: tb/ow_slave_phy_bench.sv
module ow_slave_phy_bench;
    localparam int TPU = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic od_set = 1'b0;
    logic tx_req = 1'b0;
    logic tx_bit = 1'b1;
    logic line_in;
    logic line_pull, bus_reset, rx_valid, rx_bit, tx_done, od_active;

    assign line_in = ~(m_low | line_pull);

    always #4 clk = ~clk;

    ow_slave_phy #(.TICKS_PER_US(TPU)) u_ow_slave_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .od_set   (od_set),
        .tx_req   (tx_req),
        .tx_bit   (tx_bit),
        .line_pull(line_pull),
        .bus_reset(bus_reset),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit),
        .tx_done  (tx_done),
        .od_active(od_active)
    );

    int tests = 0;
    int fails = 0;
    int n_rst = 0;
    int n_rx = 0;
    int n_txd = 0;
    logic last_rx = 1'b0;
    logic od_model = 1'b0;
    logic od_guard = 1'b1;
    logic pull_ok = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model compared every clock: speed state and permission to drive.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_reset) n_rst++;
            if (rx_valid) begin
                n_rx++;
                last_rx = rx_bit;
            end
            if (tx_done) n_txd++;
            if (!od_guard) check(od_active === od_model, "R5/R6", "od_active vs model",
                                 int'(od_active), int'(od_model));
            check(!(line_pull && !pull_ok), "R10", "unexpected pull", int'(line_pull), 0);
        end
    end

    task automatic wait_us(input int us);
        repeat (us * TPU) @(negedge clk);
    endtask

    task automatic do_reset(input int low_us, input bit od_after, input string req);
        int r0;
        r0 = n_rst;
        od_guard = 1'b1;
        m_low = 1'b1;
        wait_us(low_us);
        m_low = 1'b0;
        pull_ok = 1'b1;
        if (od_after) begin
            repeat (8 * TPU + TPU / 2) @(negedge clk);
            check(line_in == 1'b0, req, "overdrive presence at 8.5us", int'(line_in), 0);
            wait_us(22);
        end else begin
            wait_us(70);
            check(line_in == 1'b0, req, "standard presence at 70us", int'(line_in), 0);
            wait_us(130);
        end
        pull_ok = 1'b0;
        check(n_rst == r0 + 1, req, "reset strobe count", n_rst - r0, 1);
        od_model = od_after;
        check(od_active == od_after, req, "speed after reset", int'(od_active), int'(od_after));
        od_guard = 1'b0;
    endtask

    task automatic wr_slot(input bit b, input string req);
        int r0, lo, slot;
        r0   = n_rx;
        lo   = od_model ? (b ? 1 : 7) : (b ? 5 : 70);
        slot = od_model ? 10 : 90;
        m_low = 1'b1;
        wait_us(lo);
        m_low = 1'b0;
        wait_us(slot - lo);
        check(n_rx == r0 + 1, req, "write slot strobe count", n_rx - r0, 1);
        check(last_rx == b, req, "write slot bit", int'(last_rx), int'(b));
    endtask

    task automatic rd_slot(input bit b, input string req);
        int r0, t0;
        r0 = n_rx;
        t0 = n_txd;
        tx_req  = 1'b1;
        tx_bit  = b;
        pull_ok = !b;
        m_low = 1'b1;
        if (od_model) begin
            repeat (TPU) @(negedge clk);
            m_low = 1'b0;
            repeat (TPU / 2) @(negedge clk);
            check(line_in == b, req, "read bit at 1.5us", int'(line_in), int'(b));
            repeat (TPU / 2 - 1) @(negedge clk);
            check(line_in == b, req, "read bit at window end", int'(line_in), int'(b));
            wait_us(8);
        end else begin
            repeat (2 * TPU) @(negedge clk);
            m_low = 1'b0;
            wait_us(10);
            check(line_in == b, req, "read bit at 12us", int'(line_in), int'(b));
            repeat (3 * TPU - 1) @(negedge clk);
            check(line_in == b, req, "read bit at window end", int'(line_in), int'(b));
            wait_us(75);
        end
        tx_req  = 1'b0;
        tx_bit  = 1'b1;
        pull_ok = 1'b0;
        check(n_txd == t0 + 1, req, "read slot done count", n_txd - t0, 1);
        check(n_rx == r0, req, "read slot gives no rx", n_rx - r0, 0);
    endtask

    initial begin : main
        int r0, q0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R1 reset state
        check(line_pull == 1'b0, "R1", "no pull after reset", int'(line_pull), 0);
        check(od_active == 1'b0, "R1", "standard speed after reset", int'(od_active), 0);
        check(n_rst + n_rx + n_txd == 0, "R1", "no strobes after reset", n_rst + n_rx + n_txd, 0);
        od_guard = 1'b0;

        // R2 standard reset and presence
        do_reset(500, 1'b0, "R2");

        // R7 write slots at standard speed
        wr_slot(1'b1, "R7");
        wr_slot(1'b0, "R7");
        wr_slot(1'b1, "R7");

        // R8 read slots at standard speed
        rd_slot(1'b0, "R8");
        rd_slot(1'b1, "R8");

        // R9 glitch inside hold-off window is dropped
        r0 = n_rx; q0 = n_rst;
        m_low = 1'b1; wait_us(5); m_low = 1'b0;
        repeat (3) @(negedge clk);
        m_low = 1'b1; repeat (2) @(negedge clk); m_low = 1'b0;
        wait_us(100);
        check(n_rx == r0 + 1, "R9", "glitch ignored, rx count", n_rx - r0, 1);
        check(last_rx == 1'b1, "R9", "slot before glitch bit", int'(last_rx), 1);
        check(n_rst == q0, "R9", "glitch gives no reset", n_rst - q0, 0);

        // R9 low lasting past the window starts a slot
        r0 = n_rx;
        m_low = 1'b1; wait_us(5); m_low = 1'b0;
        repeat (3) @(negedge clk);
        m_low = 1'b1; wait_us(70); m_low = 1'b0;
        wait_us(30);
        check(n_rx == r0 + 2, "R9", "persisting low is a slot", n_rx - r0, 2);
        check(last_rx == 1'b0, "R9", "persisting low bit", int'(last_rx), 0);

        // R3 300us low at standard speed is not a reset
        r0 = n_rx; q0 = n_rst;
        m_low = 1'b1; wait_us(300); m_low = 1'b0;
        wait_us(70);
        check(line_in == 1'b1, "R3", "no presence after short low", int'(line_in), 1);
        wait_us(30);
        check(n_rst == q0, "R3", "no reset strobe", n_rst - q0, 0);
        check(n_rx == r0 + 1 && last_rx == 1'b0, "R3", "short low received as zero",
              int'(last_rx), 0);

        // R6 overdrive request
        od_guard = 1'b1;
        od_set = 1'b1;
        @(negedge clk);
        od_set = 1'b0;
        repeat (2) @(negedge clk);
        od_model = 1'b1;
        check(od_active == 1'b1, "R6", "overdrive after request", int'(od_active), 1);
        od_guard = 1'b0;
        wait_us(5);

        // R7 and R8 at overdrive speed
        wr_slot(1'b1, "R7");
        wr_slot(1'b0, "R7");
        rd_slot(1'b0, "R8");
        rd_slot(1'b1, "R8");

        // R4 overdrive resets that keep overdrive
        do_reset(60, 1'b1, "R4");
        do_reset(200, 1'b1, "R4");
        wr_slot(1'b1, "R4");

        // R11 30us low at overdrive speed is a write-zero
        r0 = n_rx; q0 = n_rst;
        m_low = 1'b1; wait_us(30); m_low = 1'b0;
        wait_us(20);
        check(n_rst == q0, "R11", "no reset strobe", n_rst - q0, 0);
        check(n_rx == r0 + 1 && last_rx == 1'b0, "R11", "received zero", int'(last_rx), 0);
        check(od_active == 1'b1, "R11", "overdrive kept", int'(od_active), 1);

        // R5 long reset returns to standard
        do_reset(500, 1'b0, "R5");
        wr_slot(1'b0, "R5");
        wr_slot(1'b1, "R5");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "run did not complete", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule